// File: doc/BRIEF.md
# Completion Descriptor Ring Pointer Manager

This block keeps the pointers of a circular queue of completion descriptors that lives in host memory. Hardware fills the queue and software drains it. Four pointer registers can be read and written by software: the ring base, the ring top (the highest descriptor slot), the consumer pointer and the producer pointer. Every queue slot is 16 bytes, so the low four bits of each pointer are always zero. All pointers are physical addresses and are used without translation.

A message engine offers each finished message on a valid/ready handshake, together with a flag that says whether the message should be reported. For a reported message the block drives a descriptor write request whose address is the current producer pointer. It then waits for a write-done pulse and advances the producer by one slot, or loads the base when the producer was at the top slot. Software advances the consumer by writing its register after it has read the descriptors. The block withholds ready while the queue is full, while a descriptor write is outstanding, or while bus mastering is disabled. It also reports empty and the number of pending entries, which can drive an interrupt.

Top module: `cmpl_ring_ptr`

## Requirements
- R1: After reset the top register (offset 0x60) reads 0xFFFFFFF0, and the consumer (0x64), producer (0x68) and base (0x6C) registers read 0. ringEmpty is 1, ringFull is 0 and pendCount is 0.
- R2: A register write at offset 0x60, 0x64, 0x68 or 0x6C stores the data with bits [3:0] forced to zero, and a read at that offset returns the stored value in the same cycle. A read at any other offset returns 0.
- R3: cmplReady is 0 while busMasterEn is 0.
- R4: A completion with cmplReport=1 is taken on a clock edge where cmplValid and cmplReady are both 1. From the next cycle descWrReq is 1 and descWrAddr equals the producer pointer, and cmplReady stays 0 until the write finishes.
- R5: A completion taken with cmplReport=0 raises no descWrReq and leaves the producer pointer unchanged.
- R6: A descWrDone pulse while descWrReq is 1 drops descWrReq and moves the producer up by 16. Both changes are visible in the cycle after the pulse.
- R7: When the producer equals the top register, the next advance loads the base value into the producer.
- R8: ringFull is 1 exactly when the producer's next value (after any wrap) equals the consumer. While ringFull is 1, cmplReady is 0. A software write that moves the consumer clears it.
- R9: Hardware never changes the consumer pointer. Only register writes at 0x64 change it.
- R10: ringEmpty is 1 when producer equals consumer. pendCount is (producer − consumer) / 16, taken modulo the ring size (top − base + 16).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busMasterEn | input | 1 | Bus mastering enabled; completions are taken only while it is 1 |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Register byte offset |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for regAddr, combinational |
| cmplValid | input | 1 | Completion offered |
| cmplReport | input | 1 | The offered completion needs a descriptor |
| cmplReady | output | 1 | Completion can be taken |
| descWrReq | output | 1 | Descriptor write outstanding |
| descWrAddr | output | 32 | Descriptor write address |
| descWrDone | input | 1 | Descriptor write finished, one-cycle pulse |
| ringFull | output | 1 | Queue full |
| ringEmpty | output | 1 | Queue empty |
| pendCount | output | 28 | Entries waiting for software |

## Verification
The ring is set up as four slots, and completions are pushed with and without the report flag. This separates descriptor-producing traffic from traffic that is only taken. The ring is then filled to the one-slot-free limit, which shows that full is decided on the wrapped next value and not on equal pointers. A consumer write after that must reopen the ring. One more push crosses the top slot, which checks the wrap to base and the modulo count while the producer is below the consumer. The tests also write unaligned data, read an unmapped offset and lower the bus-master enable, which checks register masking and gating.

// File: rtl/cmpl_ring_pkg.sv
package cmpl_ring_pkg;
  // Register window: four 32-bit pointers at 0x60..0x6C
  localparam logic [7:0] RING_WIN_HI = 8'h06;   // regAddr[7:4]
  // Index of each pointer, taken from regAddr[3:2]
  localparam int IDX_TOP  = 0;
  localparam int IDX_CONS = 1;
  localparam int IDX_PROD = 2;
  localparam int IDX_BASE = 3;

  typedef struct packed {
    logic advance;   // move producer to its next slot
    logic busy;      // descriptor write in flight
  } ctrlStrobe_t;
endpackage

// File: rtl/cmpl_ring_ctrl.sv
module cmpl_ring_ctrl
  import cmpl_ring_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        busMasterEn,
  input  logic        cmplValid,
  input  logic        cmplReport,
  input  logic        descWrDone,
  input  logic        ringFull,
  output logic        cmplReady,
  output logic        descWrReq,
  output ctrlStrobe_t ctrlStb
);
  typedef enum logic {ST_IDLE, ST_WRITE} state_t;
  state_t stateQ, stateD;

  always_comb begin
    cmplReady = (stateQ == ST_IDLE) && busMasterEn && !ringFull;
    descWrReq = (stateQ == ST_WRITE);
    ctrlStb.busy    = descWrReq;
    ctrlStb.advance = descWrReq && descWrDone;
    stateD = stateQ;
    case (stateQ)
      ST_IDLE:  if (cmplValid && cmplReady && cmplReport) stateD = ST_WRITE;
      ST_WRITE: if (descWrDone) stateD = ST_IDLE;
      default:  stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  // R3
  bme_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busMasterEn |-> !cmplReady);
  // R8
  full_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    ringFull |-> !cmplReady);
  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (descWrReq && !descWrDone) |=> descWrReq);
  // R5
  no_report_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmplValid && cmplReady && !cmplReport) |=> !descWrReq);
endmodule

// File: rtl/cmpl_ring_dp.sv
module cmpl_ring_dp
  import cmpl_ring_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int ENTRY_SHIFT = 4,
  parameter int REG_OFS_W   = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      regWrEn,
  input  logic [REG_OFS_W-1:0]      regAddr,
  input  logic [ADDR_W-1:0]         regWrData,
  input  ctrlStrobe_t               ctrlStb,
  output logic [ADDR_W-1:0]         regRdData,
  output logic [ADDR_W-1:0]         descWrAddr,
  output logic                      ringFull,
  output logic                      ringEmpty,
  output logic [ADDR_W-ENTRY_SHIFT-1:0] pendCount
);
  localparam int NUM_PTR = 4;
  localparam logic [ADDR_W-1:0] SLOT_BYTES = ADDR_W'(1) << ENTRY_SHIFT;
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~(SLOT_BYTES - ADDR_W'(1));
  localparam logic [ADDR_W-1:0] TOP_RESET  = ALIGN_MASK;

  logic [ADDR_W-1:0] ptrQ [NUM_PTR];
  logic [NUM_PTR-1:0] wrSel;
  logic regHit;
  logic [1:0] regIdx;
  logic [ADDR_W-1:0] nextProd, ringSize, ptrDiff;

  assign regHit = (regAddr[REG_OFS_W-1:4] == RING_WIN_HI[REG_OFS_W-5:0])
                  && (regAddr[1:0] == 2'b00);
  assign regIdx = regAddr[3:2];

  genvar gi;
  generate
    for (gi = 0; gi < NUM_PTR; gi++) begin : g_ptr
      assign wrSel[gi] = regWrEn && regHit && (regIdx == 2'(gi));
      always_ff @(posedge clk) begin
        if (!rstN)
          ptrQ[gi] <= (gi == IDX_TOP) ? TOP_RESET : '0;
        else if (wrSel[gi])
          ptrQ[gi] <= regWrData & ALIGN_MASK;
        else if (gi == IDX_PROD && ctrlStb.advance)
          ptrQ[gi] <= nextProd;
      end
    end
  endgenerate

  always_comb begin
    nextProd   = (ptrQ[IDX_PROD] == ptrQ[IDX_TOP]) ? ptrQ[IDX_BASE]
                                                  : ptrQ[IDX_PROD] + SLOT_BYTES;
    ringFull   = (nextProd == ptrQ[IDX_CONS]);
    ringEmpty  = (ptrQ[IDX_PROD] == ptrQ[IDX_CONS]);
    ringSize   = ptrQ[IDX_TOP] - ptrQ[IDX_BASE] + SLOT_BYTES;
    ptrDiff    = ptrQ[IDX_PROD] - ptrQ[IDX_CONS];
    if (ptrQ[IDX_PROD] < ptrQ[IDX_CONS]) ptrDiff = ptrDiff + ringSize;
    pendCount  = ptrDiff[ADDR_W-1:ENTRY_SHIFT];
    descWrAddr = ptrQ[IDX_PROD];
    regRdData  = regHit ? ptrQ[regIdx] : '0;
  end

  // R2
  align_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ptrQ[IDX_PROD][ENTRY_SHIFT-1:0] == '0) && (ptrQ[IDX_CONS][ENTRY_SHIFT-1:0] == '0));
  // R9
  cons_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrSel[IDX_CONS] |=> $stable(ptrQ[IDX_CONS]));
  // R6
  prod_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlStb.advance && !wrSel[IDX_PROD] && (ptrQ[IDX_PROD] != ptrQ[IDX_TOP]))
      |=> (ptrQ[IDX_PROD] == $past(ptrQ[IDX_PROD]) + SLOT_BYTES));
  // R7
  wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlStb.advance && !wrSel[IDX_PROD] && !wrSel[IDX_BASE] && (ptrQ[IDX_PROD] == ptrQ[IDX_TOP]))
      |=> (ptrQ[IDX_PROD] == ptrQ[IDX_BASE]));
  // R6
  prod_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlStb.busy && !wrSel[IDX_PROD]) |=> $stable(ptrQ[IDX_PROD]));
endmodule

// File: rtl/cmpl_ring_ptr.sv
module cmpl_ring_ptr
  import cmpl_ring_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int ENTRY_SHIFT = 4,
  parameter int REG_OFS_W   = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          busMasterEn,
  input  logic                          regWrEn,
  input  logic [REG_OFS_W-1:0]          regAddr,
  input  logic [ADDR_W-1:0]             regWrData,
  output logic [ADDR_W-1:0]             regRdData,
  input  logic                          cmplValid,
  input  logic                          cmplReport,
  output logic                          cmplReady,
  output logic                          descWrReq,
  output logic [ADDR_W-1:0]             descWrAddr,
  input  logic                          descWrDone,
  output logic                          ringFull,
  output logic                          ringEmpty,
  output logic [ADDR_W-ENTRY_SHIFT-1:0] pendCount
);
  ctrlStrobe_t ctrlStb;

  cmpl_ring_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busMasterEn(busMasterEn),
    .cmplValid(cmplValid), .cmplReport(cmplReport), .descWrDone(descWrDone),
    .ringFull(ringFull), .cmplReady(cmplReady), .descWrReq(descWrReq),
    .ctrlStb(ctrlStb)
  );

  cmpl_ring_dp #(.ADDR_W(ADDR_W), .ENTRY_SHIFT(ENTRY_SHIFT), .REG_OFS_W(REG_OFS_W)) u_dp (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .ctrlStb(ctrlStb), .regRdData(regRdData),
    .descWrAddr(descWrAddr), .ringFull(ringFull), .ringEmpty(ringEmpty),
    .pendCount(pendCount)
  );
endmodule

// File: tb/cmpl_ring_ptr_bench.sv
module cmpl_ring_ptr_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busMasterEn = 1'b0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regAddr = 8'h00;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        cmplValid = 1'b0;
  logic        cmplReport = 1'b0;
  logic        cmplReady;
  logic        descWrReq;
  logic [31:0] descWrAddr;
  logic        descWrDone = 1'b0;
  logic        ringFull;
  logic        ringEmpty;
  logic [27:0] pendCount;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;   // 250 MHz

  cmpl_ring_ptr u_cmpl_ring_ptr (
    .clk(clk), .rstN(rstN), .busMasterEn(busMasterEn), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .cmplValid(cmplValid), .cmplReport(cmplReport), .cmplReady(cmplReady),
    .descWrReq(descWrReq), .descWrAddr(descWrAddr), .descWrDone(descWrDone),
    .ringFull(ringFull), .ringEmpty(ringEmpty), .pendCount(pendCount)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  // offer one completion; sample at the negedge after the accepting edge
  task automatic offer(logic rep);
    @(negedge clk);
    cmplValid = 1'b1; cmplReport = rep;
    @(negedge clk);
    cmplValid = 1'b0; cmplReport = 1'b0;
  endtask

  task automatic finishWrite();
    @(negedge clk);
    descWrDone = 1'b1;
    @(negedge clk);
    descWrDone = 1'b0;
  endtask

  task automatic pushOne(string req, logic [31:0] expAddr);
    offer(1'b1);
    check({req, " descWrReq"}, 32'(descWrReq), 32'd1);
    check({req, " descWrAddr"}, descWrAddr, expAddr);
    finishWrite();
    check({req, " req drop"}, 32'(descWrReq), 32'd0);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    regRead(8'h60, v); check("R1 top", v, 32'hFFFF_FFF0);
    regRead(8'h64, v); check("R1 cons", v, 32'h0);
    regRead(8'h68, v); check("R1 prod", v, 32'h0);
    regRead(8'h6C, v); check("R1 base", v, 32'h0);
    check("R1 empty", 32'(ringEmpty), 32'd1);
    check("R1 full", 32'(ringFull), 32'd0);
    check("R1 count", 32'(pendCount), 32'd0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    regWrite(8'h60, 32'h1234_567F);
    regRead(8'h60, v); check("R2 masked write", v, 32'h1234_5670);
    regRead(8'h70, v); check("R2 unmapped read", v, 32'h0);
    regWrite(8'h6C, 32'h0000_1000);
    regWrite(8'h60, 32'h0000_1030);
    regWrite(8'h64, 32'h0000_1000);
    regWrite(8'h68, 32'h0000_100F);
    regRead(8'h68, v); check("R2 prod", v, 32'h0000_1000);
    regRead(8'h6C, v); check("R2 base", v, 32'h0000_1000);
    regRead(8'h64, v); check("R2 cons", v, 32'h0000_1000);
  endtask

  task automatic t_bme();
    @(negedge clk);
    busMasterEn = 1'b0; cmplValid = 1'b1; cmplReport = 1'b1;
    #1 check("R3 ready gated", 32'(cmplReady), 32'd0);
    @(negedge clk);
    cmplValid = 1'b0; cmplReport = 1'b0;
    check("R3 no request", 32'(descWrReq), 32'd0);
    busMasterEn = 1'b1;
    #1 check("R3 ready on", 32'(cmplReady), 32'd1);
  endtask

  task automatic t_report();
    logic [31:0] v;
    offer(1'b1);
    check("R4 descWrReq", 32'(descWrReq), 32'd1);
    check("R4 descWrAddr", descWrAddr, 32'h1000);
    check("R4 ready low", 32'(cmplReady), 32'd0);
    @(negedge clk);
    check("R4 req held", 32'(descWrReq), 32'd1);
    finishWrite();
    check("R6 req drop", 32'(descWrReq), 32'd0);
    regRead(8'h68, v); check("R6 prod step", v, 32'h1010);
    check("R10 count", 32'(pendCount), 32'd1);
    check("R10 empty", 32'(ringEmpty), 32'd0);
  endtask

  task automatic t_noreport();
    logic [31:0] v;
    offer(1'b0);
    check("R5 no req", 32'(descWrReq), 32'd0);
    regRead(8'h68, v); check("R5 prod kept", v, 32'h1010);
  endtask

  task automatic t_full_wrap();
    logic [31:0] v;
    pushOne("R6", 32'h1010);
    pushOne("R6", 32'h1020);
    check("R8 full", 32'(ringFull), 32'd1);
    check("R8 ready low", 32'(cmplReady), 32'd0);
    check("R10 count full", 32'(pendCount), 32'd3);
    regRead(8'h64, v); check("R9 cons unchanged", v, 32'h1000);
    regWrite(8'h64, 32'h1010);
    #1 check("R8 full cleared", 32'(ringFull), 32'd0);
    check("R8 ready back", 32'(cmplReady), 32'd1);
    pushOne("R7", 32'h1030);
    regRead(8'h68, v); check("R7 wrap to base", v, 32'h1000);
    check("R10 count wrapped", 32'(pendCount), 32'd3);
    check("R8 full again", 32'(ringFull), 32'd1);
    regRead(8'h64, v); check("R9 cons after hw", v, 32'h1010);
    regWrite(8'h64, 32'h1000);
    #1 check("R10 empty again", 32'(ringEmpty), 32'd1);
    check("R10 count zero", 32'(pendCount), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_regs();
    t_bme();
    t_report();
    t_noreport();
    t_full_wrap();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule